// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 64 interrupt request lines from peripherals. It reduces them to one interrupt level for the processor, and it answers the processor's acknowledge cycle with a vector number. Each source has three pieces of state:

- a mask bit, held in one of two 32-bit words;
- a byte-wide control register, which holds a level from 1 to 7 and a sub-priority from 0 to 7;
- a pending condition, which simply follows the peripheral's request line.

Software can rewrite a whole mask word. It can also set or clear one source's mask bit by writing the source number to one of two shortcut byte addresses. Bit 0 of the low mask word also acts as a global mask. The block never clears a request itself. Each peripheral removes its own request.

The arbiter ranks the active sources by level first and by sub-priority second. When the processor acknowledges a given level, the block returns 64 plus the number of the winning source at that level. If no active source is at that level, it returns a fixed spurious code.

Top module: `vic_top`

## Requirements
- R1: After reset, both mask words read 0xFFFFFFFF, every control register reads 0, `irq_level` is 0 and `ack_valid` is 0.
- R2: A write to address 0x00 (sources 0..31) or 0x04 (sources 32..63) loads a whole mask word. The word reads back unchanged. A mask bit of 1 keeps its source out of arbitration.
- R3: While bit 0 of the mask word at 0x00 is 1, `irq_level` is 0 whatever the requests and the other mask bits.
- R4: Writing source number n (wdata[5:0]) to address 0x08 sets mask bit n and leaves every other bit unchanged.
- R5: Writing source number n (wdata[5:0]) to address 0x09 clears mask bit n and leaves every other bit unchanged. Clearing source 0 also clears the global mask.
- R6: The control register of source n is at address 0x40+n. Its level is in bits [5:3] and its sub-priority in bits [2:0]. Bits [7:6] read as 0. A source with level 0 never takes part in arbitration.
- R7: A source is active when its request is high, its mask bit is 0, the global mask is 0 and its level is not 0. `irq_level` reports the level of the active source with the highest level, ties broken by the highest sub-priority. It is 0 when no source is active.
- R8: `irq_level` is registered. It reflects requests, masks and controls one clock edge after they change.
- R9: An `iack_req` sampled at a clock edge produces `ack_valid` = 1 after that edge. `ack_vec` is then 64 + n, where n is the active source with the highest sub-priority among those whose level equals `iack_lvl`.
- R10: If no active source has level `iack_lvl` (level 0 included), `ack_vec` is 24, the spurious code.
- R11: The block holds no pending state of its own. When a request drops, its source stops counting for `irq_level` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq_req | input | 64 | Peripheral request lines, one per source |
| irq_level | output | 3 | Level presented to the processor, 0 = none |
| iack_req | input | 1 | Acknowledge cycle request |
| iack_lvl | input | 3 | Level being acknowledged |
| ack_valid | output | 1 | Vector valid, one cycle after `iack_req` |
| ack_vec | output | 8 | Returned vector number |

## Verification
The assertions check four things on every cycle:

- a set global mask forces the level to zero on the next edge;
- an idle request bus does the same;
- every acknowledge yields `ack_valid` on the next edge;
- every returned vector is either the spurious code or lies in the 64..127 window, and a level-0 acknowledge is always spurious.

Only the bench scenarios can show the rest. These cover the ordering between level and sub-priority, the choice of source within an acknowledged level, and the exact mask contents after word and single-bit writes. They also cover the disabling effect of level 0 and the one-edge latency of the level output.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC   = 64;
  localparam int IDXW   = $clog2(NSRC);
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NWORDS = NSRC / DATA_W;

  localparam logic [ADDR_W-1:0] SET_ADDR  = 8'h08;
  localparam logic [ADDR_W-1:0] CLR_ADDR  = 8'h09;
  localparam logic [ADDR_W-1:0] CTRL_BASE = 8'h40;

  localparam logic [7:0] VEC_BASE = 8'd64;
  localparam logic [7:0] SPUR_VEC = 8'd24;

  typedef struct packed {
    logic [2:0] lvl;
    logic [2:0] sub;
  } prio_t;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [NSRC-1:0]      mask_o,
  output prio_t [NSRC-1:0]     prio_o
);
  logic [NSRC-1:0]   mask_q, mask_d;
  prio_t [NSRC-1:0]  prio_q, prio_d;
  logic              mask_en, prio_en;
  logic [ADDR_W-1:0] coff;
  logic              in_ctrl;

  assign coff    = addr - CTRL_BASE;
  assign in_ctrl = (addr >= CTRL_BASE) && (coff < ADDR_W'(NSRC));

  // next-state
  always_comb begin
    mask_d  = mask_q;
    prio_d  = prio_q;
    mask_en = 1'b0;
    prio_en = 1'b0;
    if (wr_en) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (addr == ADDR_W'(4 * w)) begin
          mask_d[w*DATA_W +: DATA_W] = wdata;
          mask_en = 1'b1;
        end
      end
      if (addr == SET_ADDR) begin
        mask_d[wdata[IDXW-1:0]] = 1'b1;
        mask_en = 1'b1;
      end
      if (addr == CLR_ADDR) begin
        mask_d[wdata[IDXW-1:0]] = 1'b0;
        mask_en = 1'b1;
      end
      if (in_ctrl) begin
        prio_d[coff[IDXW-1:0]] = prio_t'(wdata[5:0]);
        prio_en = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      prio_q <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (prio_en) prio_q <= prio_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (addr == ADDR_W'(4 * w)) rdata = mask_q[w*DATA_W +: DATA_W];
    end
    if (in_ctrl) rdata = {{(DATA_W-6){1'b0}}, prio_q[coff[IDXW-1:0]]};
  end

  assign mask_o = mask_q;
  assign prio_o = prio_q;
endmodule

// File: rtl/vic_pick.sv
module vic_pick
  import vic_pkg::*;
#(
  parameter int N  = NSRC,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  input  prio_t [N-1:0] prio,
  output logic          found,
  output logic [IW-1:0] idx,
  output prio_t         best
);
  // Strict compare: on a full tie the lower index is kept.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || (prio[i] > best))) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = prio[i];
      end
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [NSRC-1:0]      irq_req,
  output logic [2:0]           irq_level,
  input  logic                 iack_req,
  input  logic [2:0]           iack_lvl,
  output logic                 ack_valid,
  output logic [7:0]           ack_vec
);
  logic [NSRC-1:0]  mask_vec;
  prio_t [NSRC-1:0] prio_vec;
  logic [NSRC-1:0]  active, ack_cand;

  logic             top_found, ack_found;
  logic [IDXW-1:0]  top_idx, ack_idx;
  prio_t            top_best, ack_best;

  logic [2:0]       lvl_q, lvl_d;
  logic             lvl_en;
  logic             akv_q, akv_d;
  logic [7:0]       vec_q, vec_d;
  logic             vec_en;

  vic_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .mask_o (mask_vec),
    .prio_o (prio_vec)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign active[g]   = irq_req[g] & ~mask_vec[g] & ~mask_vec[0] &
                         (prio_vec[g].lvl != 3'd0);
    assign ack_cand[g] = active[g] & (prio_vec[g].lvl == iack_lvl);
  end

  vic_pick #(.N(NSRC)) u_pick_top (
    .cand  (active),
    .prio  (prio_vec),
    .found (top_found),
    .idx   (top_idx),
    .best  (top_best)
  );

  vic_pick #(.N(NSRC)) u_pick_ack (
    .cand  (ack_cand),
    .prio  (prio_vec),
    .found (ack_found),
    .idx   (ack_idx),
    .best  (ack_best)
  );

  // next-state
  always_comb begin
    lvl_d  = top_found ? top_best.lvl : 3'd0;
    lvl_en = (lvl_d != lvl_q);
    akv_d  = iack_req;
    vec_en = iack_req;
    vec_d  = (ack_found && (ack_best.lvl != 3'd0))
             ? (VEC_BASE + 8'(ack_idx)) : SPUR_VEC;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      akv_q <= 1'b0;
      vec_q <= '0;
    end else begin
      if (lvl_en) lvl_q <= lvl_d;
      akv_q <= akv_d;
      if (vec_en) vec_q <= vec_d;
    end
  end

  assign irq_level = lvl_q;
  assign ack_valid = akv_q;
  assign ack_vec   = vec_q;
endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vic_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_req,
  input logic            gmask,
  input logic [2:0]      irq_level,
  input logic            iack_req,
  input logic [2:0]      iack_lvl,
  input logic            ack_valid,
  input logic [7:0]      ack_vec
);
  assert_gmask_silences_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gmask |=> (irq_level == 3'd0));

  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req == '0) |=> (irq_level == 3'd0));

  assert_ack_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    iack_req |=> ack_valid);

  assert_vec_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> ((ack_vec == SPUR_VEC) || (ack_vec[7:6] == 2'b01)));

  assert_lvl0_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_req && (iack_lvl == 3'd0)) |=> (ack_vec == SPUR_VEC));
endmodule

bind vic_top vic_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req   (irq_req),
  .gmask     (mask_vec[0]),
  .irq_level (irq_level),
  .iack_req  (iack_req),
  .iack_lvl  (iack_lvl),
  .ack_valid (ack_valid),
  .ack_vec   (ack_vec)
);

// File: tb/vic_top_bench.sv
module vic_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [63:0] irq_req;
  logic [2:0]  irq_level;
  logic        iack_req;
  logic [2:0]  iack_lvl;
  logic        ack_valid;
  logic [7:0]  ack_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // scoreboard queues: kind 0 = level, 1 = rdata, 2 = vector (valid expected)
  int          kind_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  vic_top u_vic_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_req(irq_req), .irq_level(irq_level),
    .iack_req(iack_req), .iack_lvl(iack_lvl), .ack_valid(ack_valid),
    .ack_vec(ack_vec)
  );

  task automatic push(input int k, input logic [31:0] e, input string t);
    kind_q.push_back(k);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    addr = a;
    @(posedge clk); #1;
    push(1, e, t);
  endtask

  task automatic exp_lvl(input logic [2:0] e, input string t);
    @(posedge clk); #1;
    push(0, 32'(e), t);
  endtask

  task automatic set_req(input logic [63:0] r);
    @(negedge clk);
    irq_req = r;
  endtask

  task automatic exp_ack(input logic [2:0] l, input logic [7:0] e, input string t);
    @(negedge clk);
    iack_req = 1'b1; iack_lvl = l;
    @(posedge clk); #1;
    push(2, 32'(e), t);
    @(negedge clk);
    iack_req = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (kind_q.size() > 0) begin
        int          k;
        logic [31:0] e;
        logic [31:0] act;
        string       t;
        k = kind_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        act = (k == 0) ? 32'(irq_level) : (k == 1) ? rdata :
              {23'd0, ack_valid, ack_vec};
        if (k == 2) e = {23'd0, 1'b1, e[7:0]};
        checks++;
        if (act !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, act, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    irq_req = '0; iack_req = 1'b0; iack_lvl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    exp_rd(8'h00, 32'hFFFF_FFFF, "R1 mask low");
    exp_rd(8'h04, 32'hFFFF_FFFF, "R1 mask high");
    exp_rd(8'h45, 32'h0, "R1 ctrl");
    exp_lvl(3'd0, "R1 level");

    // R6 control registers
    wr(8'h45, 32'h1A);             // src5  lvl3 sub2
    wr(8'h68, 32'h1D);             // src40 lvl3 sub5
    wr(8'h4A, 32'h30);             // src10 lvl6 sub0
    wr(8'h54, 32'h07);             // src20 lvl0 sub7
    wr(8'h46, 32'hFF);
    exp_rd(8'h45, 32'h1A, "R6 ctrl readback");
    exp_rd(8'h46, 32'h3F, "R6 upper bits zero");

    // R5 clear-one
    wr(8'h09, 32'd5);  wr(8'h09, 32'd40); wr(8'h09, 32'd10);
    wr(8'h09, 32'd20); wr(8'h09, 32'd0);
    exp_rd(8'h00, 32'hFFEF_FBDE, "R5 clear low");
    exp_rd(8'h04, 32'hFFFF_FEFF, "R5 clear high");

    // R8 one-edge latency, R7 single source
    set_req(64'h1 << 5);
    exp_lvl(3'd3, "R8 level after one edge");

    // R7 / R9 sub-priority within level
    set_req((64'h1 << 5) | (64'h1 << 40));
    exp_lvl(3'd3, "R7 same level");
    exp_ack(3'd3, 8'd104, "R9 higher sub wins");

    // R7 level dominates
    set_req((64'h1 << 5) | (64'h1 << 40) | (64'h1 << 10));
    exp_lvl(3'd6, "R7 higher level wins");
    exp_ack(3'd6, 8'd74, "R9 ack level 6");
    exp_ack(3'd3, 8'd104, "R9 ack lower level");

    // R6 level 0 disables, R10 spurious
    set_req(64'h1 << 20);
    exp_lvl(3'd0, "R6 level zero disabled");
    exp_ack(3'd2, 8'd24, "R10 nothing at level");
    exp_ack(3'd0, 8'd24, "R10 level zero ack");

    // R4 set-one
    wr(8'h08, 32'd40);
    exp_rd(8'h04, 32'hFFFF_FFFF, "R4 set high");
    set_req((64'h1 << 5) | (64'h1 << 40));
    exp_ack(3'd3, 8'd69, "R4 masked source skipped");

    // R3 global mask
    wr(8'h00, 32'h1);
    exp_lvl(3'd0, "R3 global mask");
    exp_rd(8'h00, 32'h1, "R3 readback");
    wr(8'h00, 32'h0);
    exp_lvl(3'd3, "R3 global mask released");

    // R2 full word writes
    wr(8'h04, 32'h0);
    exp_rd(8'h04, 32'h0, "R2 high readback");
    exp_ack(3'd3, 8'd104, "R2 unmasked by word");
    wr(8'h00, 32'h20);
    set_req(64'h1 << 5);
    exp_lvl(3'd0, "R2 masked by word");

    // R11 request drop
    wr(8'h00, 32'h0);
    exp_lvl(3'd3, "R11 request present");
    set_req(64'h0);
    exp_lvl(3'd0, "R11 request dropped");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule